// File: doc/BRIEF.md
# PCI Clock-Run Idle Controller

This block decides when the PCI clock may be released. It watches a bus-activity input on every PCI clock edge and counts consecutive idle clocks. Once the count reaches a fixed limit (26 by default), it deasserts the active-low clock-run output. Clock-gating logic elsewhere can then stop the PCI clock. Any bus activity clears the count and asserts clock-run again on the following clock.

Two static control inputs shape the behaviour. A hold input keeps clock-run asserted permanently. An active-high stop-disable input controls the active-low clock-stop output. With stop-disable at 0, which is the normal setting, clock-stop is asserted exactly while clock-run is deasserted. With stop-disable at 1, clock-stop is never asserted. Both outputs come straight from flip-flops, so neither glitches.

Top module: `pci_clkrun_idle`

## Requirements
- R1: A synchronous reset (rst_ni low at a clock edge) sets clkrun_n_o to 0 (asserted) and clkstop_n_o to 1 (deasserted), and clears the idle count. After reset, 26 more idle clocks are needed before clkrun_n_o rises.
- R2: With run_hold_i = 0, clkrun_n_o goes to 1 after the edge that samples the 26th consecutive clock with bus_busy_i = 0. After the 25th such edge it is still 0.
- R3: An edge that samples bus_busy_i = 1 clears the idle count, so the next deassertion needs 26 fresh idle clocks.
- R4: An edge that samples bus_busy_i = 1 sets clkrun_n_o to 0 and clkstop_n_o to 1 at that same edge.
- R5: The idle count saturates at the limit. While the bus stays idle, clkrun_n_o stays at 1 indefinitely and never falls back to 0 through wrap-around.
- R6: While run_hold_i = 1, clkrun_n_o is 0 whatever the bus does. Idle counting goes on during the hold, so if the limit has already been reached, clearing run_hold_i lets clkrun_n_o rise at the next edge.
- R7: With stop_off_i = 0, clkstop_n_o is 0 in exactly the cycles in which clkrun_n_o is 1.
- R8: With stop_off_i = 1, clkstop_n_o stays 1 even while clkrun_n_o is 1. A change of stop_off_i during an idle period takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_busy_i | input | 1 | 1 when the bus shows activity this clock |
| run_hold_i | input | 1 | 1 keeps clock-run asserted permanently |
| stop_off_i | input | 1 | 1 disables the clock-stop output; 0 enables it |
| clkrun_n_o | output | 1 | Clock-run request, active low |
| clkstop_n_o | output | 1 | Clock-stop indication, active low |

## Verification
The timeout boundary is tested with idle runs of exactly 25 clocks and then one more clock, which separates a correct limit from an off-by-one. A busy pulse after 25 idle clocks, followed by another 25 idle clocks, separates a counter that clears on activity from one that only pauses. A 200-clock idle stretch exposes wrap-around. Toggling the hold and stop-disable inputs in the middle of a long idle period shows whether the idle count keeps running under hold and whether the stop output follows its enable at the next edge. A reset in the middle of an idle period confirms that the count is cleared as well as the outputs.

// File: rtl/clkrun_pkg.sv
// Package: shared constants for the PCI clock-run idle controller.
// Assumes: one PCI clock domain; all users import this package.
package clkrun_pkg;
    // Default number of consecutive idle PCI clocks before clock-run drops.
    localparam int unsigned CLKRUN_IDLE_DEFAULT = 26;
endpackage

// File: rtl/clkrun_idle_counter.sv
// Module: clkrun_idle_counter
// Counts consecutive idle clocks, saturating at IDLE_LIMIT.
// It flags (combinationally) that the limit is reached at the coming edge.
// Assumes: bus_busy_i is synchronous to clk_i; IDLE_LIMIT >= 1.
module clkrun_idle_counter #(
    parameter int unsigned IDLE_LIMIT = clkrun_pkg::CLKRUN_IDLE_DEFAULT,
    localparam int unsigned CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_busy_i,
    output logic limit_hit_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear on activity, hold at the limit, otherwise step.
    always_comb begin
        if (bus_busy_i)          cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = LIMIT;
        else                     cnt_d = cnt_q + CNT_W'(1);
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // The limit is reached as of the coming edge.
    assign limit_hit_o = (cnt_d == LIMIT);

    // R3: activity clears the count.
    a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_busy_i |=> (cnt_q == '0));
    // R2: every idle clock below the limit advances the count by one.
    a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_busy_i && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    // R5: the count holds at the limit while the bus stays idle.
    a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_busy_i && cnt_q == LIMIT) |=> (cnt_q == LIMIT));
endmodule

// File: rtl/clkrun_out_stage.sv
// Module: clkrun_out_stage
// Registers the clock-run and clock-stop states and drives them out active low.
// Assumes: limit_hit_i is already 0 whenever bus_busy_i is 1.
module clkrun_out_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_busy_i,
    input  logic run_hold_i,
    input  logic stop_off_i,
    input  logic limit_hit_i,
    output logic clkrun_n_o,
    output logic clkstop_n_o
);
    logic run_d, run_q;
    logic stop_d, stop_q;

    // Clock-run stays requested under hold, on activity, or below the limit.
    always_comb begin
        run_d  = run_hold_i | bus_busy_i | ~limit_hit_i;
        stop_d = ~stop_off_i & ~run_d;
    end

    // State flops: the reset value requests the clock and clears the stop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q  <= 1'b1;
            stop_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            stop_q <= stop_d;
        end
    end

    // Active-low outputs straight from flops.
    assign clkrun_n_o  = ~run_q;
    assign clkstop_n_o = ~stop_q;

    // R1: reset leaves clock-run asserted and clock-stop released.
    a_r1_reset: assert property (@(posedge clk_i)
        !rst_ni |=> (run_q && !stop_q));
    // R4: activity requests the clock and releases the stop at once.
    a_r4_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_busy_i |=> (run_q && !stop_q));
    // R6: hold forces clock-run.
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_hold_i |=> run_q);
    // R2: reaching the limit without hold drops clock-run.
    a_r2_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (limit_hit_i && !run_hold_i) |=> !run_q);
    // R7: clock-stop only while clock-run is dropped.
    a_r7_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_q |-> !run_q);
    // R8: disabled stop never asserts.
    a_r8_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_off_i |=> !stop_q);
endmodule

// File: rtl/pci_clkrun_idle.sv
// Module: pci_clkrun_idle (top)
// Drops the PCI clock-run request after IDLE_LIMIT idle clocks and optionally
// signals clock-stop while it is dropped.
// Assumes: all inputs synchronous to clk_i; control inputs are quasi-static.
module pci_clkrun_idle #(
    parameter int unsigned IDLE_LIMIT = clkrun_pkg::CLKRUN_IDLE_DEFAULT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bus_busy_i,
    input  logic run_hold_i,
    input  logic stop_off_i,
    output logic clkrun_n_o,
    output logic clkstop_n_o
);
    logic limit_hit;

    // Idle clock counter.
    clkrun_idle_counter #(.IDLE_LIMIT(IDLE_LIMIT)) i_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_busy_i  (bus_busy_i),
        .limit_hit_o (limit_hit)
    );

    // Output state registers.
    clkrun_out_stage i_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_busy_i  (bus_busy_i),
        .run_hold_i  (run_hold_i),
        .stop_off_i  (stop_off_i),
        .limit_hit_i (limit_hit),
        .clkrun_n_o  (clkrun_n_o),
        .clkstop_n_o (clkstop_n_o)
    );
endmodule

// File: tb/test_pci_clkrun_idle.sv
module test_pci_clkrun_idle;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0, hold = 1'b0, off = 1'b0;
    logic run_n, stop_n;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    pci_clkrun_idle i_pci_clkrun_idle (
        .clk_i(clk), .rst_ni(rst_n), .bus_busy_i(busy),
        .run_hold_i(hold), .stop_off_i(off),
        .clkrun_n_o(run_n), .clkstop_n_o(stop_n)
    );

    typedef struct packed {
        logic       busy;
        logic       hold;
        logic       off;
        logic [8:0] cycles;
        logic       exp_run_n;
        logic       exp_stop_n;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b0, 9'd25,  1'b0, 1'b1, 4'd2}, // R2: 25 idle, still asserted
        '{1'b0, 1'b0, 1'b0, 9'd1,   1'b1, 1'b0, 4'd7}, // R2/R7: 26th idle drops, stop on
        '{1'b0, 1'b0, 1'b0, 9'd200, 1'b1, 1'b0, 4'd5}, // R5: no wrap
        '{1'b1, 1'b0, 1'b0, 9'd1,   1'b0, 1'b1, 4'd4}, // R4: wake at same edge
        '{1'b0, 1'b0, 1'b0, 9'd25,  1'b0, 1'b1, 4'd3}, // R3
        '{1'b1, 1'b0, 1'b0, 9'd1,   1'b0, 1'b1, 4'd3}, // R3: interrupt
        '{1'b0, 1'b0, 1'b0, 9'd25,  1'b0, 1'b1, 4'd3}, // R3: count restarted
        '{1'b0, 1'b0, 1'b1, 9'd1,   1'b1, 1'b1, 4'd8}, // R8: dropped, stop held off
        '{1'b0, 1'b0, 1'b1, 9'd50,  1'b1, 1'b1, 4'd8}, // R8
        '{1'b0, 1'b0, 1'b0, 9'd1,   1'b1, 1'b0, 4'd8}, // R8: enable takes effect next edge
        '{1'b0, 1'b1, 1'b0, 9'd1,   1'b0, 1'b1, 4'd6}, // R6: hold reasserts
        '{1'b0, 1'b1, 1'b0, 9'd100, 1'b0, 1'b1, 4'd6}, // R6
        '{1'b0, 1'b0, 1'b0, 9'd1,   1'b1, 1'b0, 4'd6}, // R6: drop at next edge after hold
        '{1'b1, 1'b1, 1'b0, 9'd3,   1'b0, 1'b1, 4'd6}  // R6
    };

    task automatic check(input int req, input logic er, input logic es);
        n_chk++;
        if (run_n !== er || stop_n !== es) begin
            n_fail++;
            $display("FAIL R%0d: clkrun_n=%b clkstop_n=%b expected %b %b",
                     req, run_n, stop_n, er, es);
        end
    endtask

    // Inputs change at a falling edge; outputs are sampled at a falling edge.
    task automatic apply(input logic b, input logic h, input logic o, input int n);
        busy = b; hold = h; off = o;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        apply(1'b0, 1'b0, 1'b0, 3);
        check(1, 1'b0, 1'b1);          // R1: reset state
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            apply(TBL[v].busy, TBL[v].hold, TBL[v].off, int'(TBL[v].cycles));
            check(int'(TBL[v].req), TBL[v].exp_run_n, TBL[v].exp_stop_n);
        end
        // R1: reset in the middle of an idle period clears the count
        apply(1'b0, 1'b0, 1'b0, 30);
        check(2, 1'b1, 1'b0);
        rst_n = 1'b0;
        apply(1'b0, 1'b0, 1'b0, 1);
        check(1, 1'b0, 1'b1);
        rst_n = 1'b1;
        apply(1'b0, 1'b0, 1'b0, 25);
        check(1, 1'b0, 1'b1);
        apply(1'b0, 1'b0, 1'b0, 1);
        check(1, 1'b1, 1'b0);
        // R8: disabling the stop while dropped releases it at the next edge
        apply(1'b0, 1'b0, 1'b1, 1);
        check(8, 1'b1, 1'b1);
        finish_run();
    end
endmodule